// File: doc/BRIEF.md
# System-Control Coprocessor Exception Unit

This block holds the system-control state of a small 32-bit core. It keeps a status word, a cause word, the saved exception PC, the faulting address and a fixed processor identifier. The pipeline reads and writes these through a 5-bit register number. The read path is combinational and a write lands on the next clock edge.

The pipeline raises an exception by presenting a cause code, the PC of the faulting instruction, a delay-slot flag and a PC-adjust flag. In that same cycle the block drives a redirect strobe, the handler vector and the vector plus one instruction. On the following edge it saves the PC and the cause, and it pushes the three-level kernel/interrupt-enable stack held in the low status bits. A single external interrupt line marks a pending interrupt in the cause word. When the status word enables it, the line also raises an interrupt exception by itself. A coprocessor function strobe carrying the return-from-exception code pops the mode stack.

Top module: `cp0_exc_unit`

## Requirements
- R1: After reset, Status (12), Cause (13), EPC (14) and BadVAddr (8) read zero, and register 15 always reads 2.
- R2: Registers 3, 5, 6, 7, 9 and 11 read zero and ignore writes. Writes to registers 8, 14 and 15 have no effect.
- R3: A write to register 12 or 13 is visible on a read in the following cycle.
- R4: When an exception is taken, Status[5:0] becomes {Status[3:0], 2'b00} and Status[31:6] is unchanged.
- R5: When an exception is taken, Cause[7:0] is cleared, Cause[6:2] receives the cause code and Cause[31] receives the delay-slot flag. The other Cause bits are kept.
- R6: When an exception is taken, EPC becomes the request PC, minus 4 if the adjust flag is set, minus a further 4 if the delay-slot flag is set.
- R7: BadVAddr is loaded with the request PC only for cause codes 4 and 5. For any other code it is unchanged.
- R8: In the cycle of an exception, redirect is 1 and new_pc is 0x80000080 when Status[22] is 0, or 0xBFC00180 when Status[22] is 1. new_next_pc is always new_pc + 4.
- R9: Whenever irq_line is 1 at a clock edge, Cause[10] is 1 after that edge, whether or not the interrupt is taken.
- R10: irq_taken is 1 only when irq_line, Status[0] and Status[10] are all 1. A taken interrupt with no exception request acts as an exception with code 0, adjust flag 0 and the presented PC and delay-slot flag.
- R11: A coprocessor function strobe with code 0x10 sets Status[3:0] to Status[5:2] and keeps Status[5:4]. Any other function code has no effect.
- R12: An exception request wins over a same-cycle interrupt (its code is used) and over a same-cycle write to Status or Cause (the write is dropped). A return-from-exception wins over a same-cycle Status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| exc_req | input | 1 | Exception request |
| exc_code | input | 5 | Exception cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_pc_dec | input | 1 | Subtract one instruction from the saved PC |
| irq_line | input | 1 | External interrupt line |
| cop_fn_valid | input | 1 | Coprocessor function strobe |
| cop_fn | input | 6 | Coprocessor function code |
| redirect | output | 1 | Exception taken this cycle |
| irq_taken | output | 1 | Interrupt taken this cycle |
| new_pc | output | 32 | Handler vector |
| new_next_pc | output | 32 | Handler vector plus 4 |

## Verification
The bench builds the unit with its default parameters. These place the interrupt mask and pending bits at position 10 and the boot-vector select at bit 22, and they use the two standard handler vectors with a 4-byte instruction step. With these values every cause code, both vectors and all four combinations of delay-slot and adjust flags can be reached. So can the collisions between exceptions, interrupts, returns and register writes. Random traffic mixes these collisions, and directed cases pin down the double PC adjustment, the masked-interrupt case and the pop that keeps the old mode pair.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
   localparam logic [4:0] RN_BADV   = 5'd8;
   localparam logic [4:0] RN_STATUS = 5'd12;
   localparam logic [4:0] RN_CAUSE  = 5'd13;
   localparam logic [4:0] RN_EPC    = 5'd14;
   localparam logic [4:0] RN_PRID   = 5'd15;

   localparam logic [4:0] EC_INT        = 5'h00;
   localparam logic [4:0] EC_FETCH_ADDR = 5'h04;
   localparam logic [4:0] EC_STORE_ADDR = 5'h05;
   localparam logic [4:0] EC_SYSCALL    = 5'h08;
   localparam logic [4:0] EC_BREAK      = 5'h09;
   localparam logic [4:0] EC_RESV       = 5'h0A;
   localparam logic [4:0] EC_OVF        = 5'h0C;

   localparam logic [5:0] FN_RET_EXC = 6'h10;

   typedef struct packed {
      logic        take;
      logic [4:0]  code;
      logic [31:0] pc;
      logic        in_delay;
      logic        pc_dec;
   } trap_t;

   function automatic logic is_addr_fault(input logic [4:0] code);
      return (code == EC_FETCH_ADDR) || (code == EC_STORE_ADDR);
   endfunction
endpackage

// File: rtl/cp0_mode_stack.sv
module cp0_mode_stack #(
   parameter int W      = 32,
   parameter int LEVELS = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] status_q
);
   localparam int STACK_W = 2 * LEVELS;

   logic [STACK_W-1:0] stk_push;
   logic [STACK_W-1:0] stk_pop;

   for (genvar p = 0; p < LEVELS; p++) begin : g_pair
      if (p == 0) begin : g_bottom
         assign stk_push[1:0] = 2'b00;
      end else begin : g_shift_up
         assign stk_push[2*p+1 -: 2] = status_q[2*p-1 -: 2];
      end
      if (p == LEVELS - 1) begin : g_top
         assign stk_pop[2*p+1 -: 2] = status_q[2*p+1 -: 2];
      end else begin : g_shift_down
         assign stk_pop[2*p+1 -: 2] = status_q[2*p+3 -: 2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      status_q <= '0;
      else if (push)   status_q <= {status_q[W-1:STACK_W], stk_push};
      else if (pop)    status_q <= {status_q[W-1:STACK_W], stk_pop};
      else if (wr_en)  status_q <= wr_data;
   end
endmodule

// File: rtl/cp0_cause_reg.sv
module cp0_cause_reg #(
   parameter int W       = 32,
   parameter int PEND_BIT = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cp0_pkg::trap_t trap,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          irq_line,
   output logic [W-1:0]  cause_q
);
   logic [W-1:0] cause_d;

   always_comb begin
      cause_d = cause_q;
      if (trap.take) begin
         cause_d[7:0]  = 8'h00;
         cause_d[6:2]  = trap.code;
         cause_d[W-1]  = trap.in_delay;
      end else if (wr_en) begin
         cause_d = wr_data;
      end
      if (irq_line) cause_d[PEND_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_d;
   end
endmodule

// File: rtl/cp0_epc_unit.sv
module cp0_epc_unit #(
   parameter int W          = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  cp0_pkg::trap_t trap,
   output logic [W-1:0]   epc_q,
   output logic [W-1:0]   badv_q
);
   localparam logic [W-1:0] STEP = W'(INSN_BYTES);

   logic [W-1:0] dec_amt;
   logic [W-1:0] slot_amt;

   assign dec_amt  = trap.pc_dec   ? STEP : '0;
   assign slot_amt = trap.in_delay ? STEP : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q  <= '0;
         badv_q <= '0;
      end else if (trap.take) begin
         epc_q <= trap.pc - dec_amt - slot_amt;
         if (cp0_pkg::is_addr_fault(trap.code)) badv_q <= trap.pc;
      end
   end
endmodule

// File: rtl/cp0_vector_sel.sv
module cp0_vector_sel #(
   parameter int          W          = 32,
   parameter logic [31:0] VEC_RAM    = 32'h8000_0080,
   parameter logic [31:0] VEC_ROM    = 32'hBFC0_0180,
   parameter int          INSN_BYTES = 4
) (
   input  logic         boot_sel,
   output logic [W-1:0] vec_pc,
   output logic [W-1:0] vec_next
);
   assign vec_pc   = boot_sel ? W'(VEC_ROM) : W'(VEC_RAM);
   assign vec_next = vec_pc + W'(INSN_BYTES);
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit #(
   parameter int          DATA_W     = 32,
   parameter int          REGNUM_W   = 5,
   parameter int          FN_W       = 6,
   parameter int          CODE_W     = 5,
   parameter int          MODE_LEVELS = 3,
   parameter int          INSN_BYTES = 4,
   parameter int          IRQ_BIT    = 10,
   parameter int          BEV_BIT    = 22,
   parameter logic [31:0] PRID_VALUE = 32'd2,
   parameter logic [31:0] VEC_RAM    = 32'h8000_0080,
   parameter logic [31:0] VEC_ROM    = 32'hBFC0_0180
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic [REGNUM_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                exc_req,
   input  logic [CODE_W-1:0]   exc_code,
   input  logic [DATA_W-1:0]   exc_pc,
   input  logic                exc_in_delay,
   input  logic                exc_pc_dec,
   input  logic                irq_line,
   input  logic                cop_fn_valid,
   input  logic [FN_W-1:0]     cop_fn,
   output logic                redirect,
   output logic                irq_taken,
   output logic [DATA_W-1:0]   new_pc,
   output logic [DATA_W-1:0]   new_next_pc
);
   import cp0_pkg::*;

   if (DATA_W != 32) begin : g_bad_width
      $error("cp0_exc_unit: DATA_W must be 32");
   end
   if (REGNUM_W != 5 || CODE_W != 5 || FN_W != 6) begin : g_bad_fields
      $error("cp0_exc_unit: register, code and function widths are fixed");
   end
   if (IRQ_BIT < 8 || IRQ_BIT > 15) begin : g_bad_irq
      $error("cp0_exc_unit: IRQ_BIT must lie in the mask/pending byte");
   end
   if (2 * MODE_LEVELS > 8 || MODE_LEVELS < 2) begin : g_bad_levels
      $error("cp0_exc_unit: mode stack must fit below the code field");
   end
   if (BEV_BIT < 16 || BEV_BIT >= DATA_W) begin : g_bad_bev
      $error("cp0_exc_unit: BEV_BIT out of range");
   end

   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] cause_q;
   logic [DATA_W-1:0] epc_q;
   logic [DATA_W-1:0] badv_q;
   trap_t             trap;
   logic              irq_ok;
   logic              ret_pop;
   logic              status_wr;
   logic              cause_wr;

   assign irq_ok        = irq_line & status_q[0] & status_q[IRQ_BIT];
   assign trap.take     = exc_req | irq_ok;
   assign trap.code     = exc_req ? exc_code : EC_INT;
   assign trap.pc       = exc_pc;
   assign trap.in_delay = exc_in_delay;
   assign trap.pc_dec   = exc_req & exc_pc_dec;

   assign ret_pop   = cop_fn_valid & (cop_fn == FN_RET_EXC);
   assign status_wr = reg_wr_en & (reg_addr == RN_STATUS);
   assign cause_wr  = reg_wr_en & (reg_addr == RN_CAUSE);

   cp0_mode_stack #(.W(DATA_W), .LEVELS(MODE_LEVELS)) u_mode_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (trap.take),
      .pop      (ret_pop),
      .wr_en    (status_wr),
      .wr_data  (reg_wdata),
      .status_q (status_q)
   );

   cp0_cause_reg #(.W(DATA_W), .PEND_BIT(IRQ_BIT)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap     (trap),
      .wr_en    (cause_wr),
      .wr_data  (reg_wdata),
      .irq_line (irq_line),
      .cause_q  (cause_q)
   );

   cp0_epc_unit #(.W(DATA_W), .INSN_BYTES(INSN_BYTES)) u_epc (
      .clk    (clk),
      .rst_n  (rst_n),
      .trap   (trap),
      .epc_q  (epc_q),
      .badv_q (badv_q)
   );

   cp0_vector_sel #(
      .W(DATA_W), .VEC_RAM(VEC_RAM), .VEC_ROM(VEC_ROM), .INSN_BYTES(INSN_BYTES)
   ) u_vec (
      .boot_sel (status_q[BEV_BIT]),
      .vec_pc   (new_pc),
      .vec_next (new_next_pc)
   );

   always_comb begin
      case (reg_addr)
         RN_BADV:   reg_rdata = badv_q;
         RN_STATUS: reg_rdata = status_q;
         RN_CAUSE:  reg_rdata = cause_q;
         RN_EPC:    reg_rdata = epc_q;
         RN_PRID:   reg_rdata = PRID_VALUE;
         default:   reg_rdata = '0;
      endcase
   end

   assign redirect  = trap.take;
   assign irq_taken = irq_ok;
endmodule

// File: rtl/cp0_exc_unit_chk.sv
module cp0_exc_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        exc_req,
   input logic [4:0]  exc_code,
   input logic [31:0] exc_pc,
   input logic        exc_in_delay,
   input logic        exc_pc_dec,
   input logic        irq_line,
   input logic        cop_fn_valid,
   input logic [5:0]  cop_fn,
   input logic [4:0]  reg_addr,
   input logic [31:0] reg_rdata,
   input logic        redirect,
   input logic [31:0] new_pc,
   input logic [31:0] new_next_pc,
   input logic [31:0] status_q,
   input logic [31:0] cause_q,
   input logic [31:0] epc_q,
   input logic [31:0] badv_q
);
   AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 5'd15) |-> (reg_rdata == 32'd2)); // R1

   AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00})
                   && (status_q[31:6] == $past(status_q[31:6]))); // R4

   AST_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (cause_q[31] == $past(exc_in_delay)) && (cause_q[1:0] == 2'b00)); // R5

   AST_EPC_ADJUST: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> epc_q == $past(exc_pc) - ($past(exc_pc_dec) ? 32'd4 : 32'd0)
                           - ($past(exc_in_delay) ? 32'd4 : 32'd0)); // R6

   AST_BADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && exc_req && exc_code != 5'd4 && exc_code != 5'd5) |=>
      (badv_q == $past(badv_q))); // R7

   AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (new_next_pc == new_pc + 32'd4) &&
                   (new_pc == 32'h8000_0080 || new_pc == 32'hBFC0_0180)); // R8

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line |=> cause_q[10]); // R9

   AST_RET_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_fn_valid && cop_fn == 6'h10 && !redirect) |=>
      (status_q[5:0] == {$past(status_q[5:4]), $past(status_q[5:2])})); // R11

   AST_REQ_CODE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (cause_q[6:2] == $past(exc_code))); // R12
endmodule

bind cp0_exc_unit cp0_exc_unit_chk u_chk (.*);

// File: tb/test_cp0_exc_unit.sv
module test_cp0_exc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_code = '0;
   logic [31:0] exc_pc = '0;
   logic        exc_in_delay = 1'b0;
   logic        exc_pc_dec = 1'b0;
   logic        irq_line = 1'b0;
   logic        cop_fn_valid = 1'b0;
   logic [5:0]  cop_fn = '0;
   logic        redirect;
   logic        irq_taken;
   logic [31:0] new_pc;
   logic [31:0] new_next_pc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_st, m_ca, m_epc, m_bv;

   always #4 clk = ~clk;

   cp0_exc_unit i_cp0_exc_unit (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [4:0] a);
      case (a)
         5'd8:  return m_bv;
         5'd12: return m_st;
         5'd13: return m_ca;
         5'd14: return m_epc;
         5'd15: return 32'd2;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string read_tag(input logic [4:0] a);
      if (a == 5'd12 || a == 5'd13) return "R3";
      if (a == 5'd14) return "R6";
      if (a == 5'd8) return "R7";
      if (a == 5'd15) return "R1";
      return "R2";
   endfunction

   task automatic step(input logic wr, input logic [4:0] addr, input logic [31:0] wd,
                       input logic ex, input logic [4:0] code, input logic [31:0] pc,
                       input logic dly, input logic dec, input logic irq,
                       input logic fv, input logic [5:0] fn);
      logic irq_exp, take;
      @(negedge clk);
      reg_wr_en = wr; reg_addr = addr; reg_wdata = wd;
      exc_req = ex; exc_code = code; exc_pc = pc; exc_in_delay = dly; exc_pc_dec = dec;
      irq_line = irq; cop_fn_valid = fv; cop_fn = fn;
      #1;
      irq_exp = irq && m_st[0] && m_st[10];
      take = ex || irq_exp;
      chk("R10", "irq_taken", {31'd0, irq_taken}, {31'd0, irq_exp});
      chk(ex ? "R8" : "R10", "redirect", {31'd0, redirect}, {31'd0, take});
      chk("R8", "new_pc", new_pc, m_st[22] ? 32'hBFC0_0180 : 32'h8000_0080);
      chk("R8", "new_next_pc", new_next_pc, m_st[22] ? 32'hBFC0_0184 : 32'h8000_0084);
      chk(read_tag(addr), "reg_rdata", reg_rdata, exp_read(addr));
      @(posedge clk);
      if (take) begin
         logic [4:0] c;
         c = ex ? code : 5'd0;
         m_st = {m_st[31:6], m_st[3:0], 2'b00};
         m_ca = {dly, m_ca[30:8], 1'b0, c, 2'b00};
         m_epc = pc - ((ex && dec) ? 32'd4 : 32'd0) - (dly ? 32'd4 : 32'd0);
         if (c == 5'd4 || c == 5'd5) m_bv = pc;
      end else begin
         if (fv && fn == 6'h10) m_st = {m_st[31:6], m_st[5:4], m_st[5:2]};
         else if (wr && addr == 5'd12) m_st = wd;
         if (wr && addr == 5'd13) m_ca = wd;
      end
      if (irq) m_ca[10] = 1'b1;
   endtask

   task automatic rd(input logic [4:0] a);
      step(1'b0, a, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      m_st = '0; m_ca = '0; m_epc = '0; m_bv = '0;
      void'($urandom(32'd4177));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset values and the fixed identifier
      rd(5'd12); rd(5'd13); rd(5'd14); rd(5'd8); rd(5'd15);
      // R2: debug registers and read-only registers ignore writes
      wr(5'd3, 32'hFFFF_FFFF); rd(5'd3);
      wr(5'd11, 32'h1234_5678); rd(5'd11);
      wr(5'd14, 32'hCAFE_0000); rd(5'd14);
      wr(5'd8, 32'h0BAD_0000); rd(5'd8);
      wr(5'd15, 32'h0000_0077); rd(5'd15);
      // R3: writable Status and Cause
      wr(5'd12, 32'h0000_0017); rd(5'd12);
      wr(5'd13, 32'h3000_FF00); rd(5'd13);
      // R4 R5 R6: syscall in a delay slot with the adjust flag
      step(1'b0, 5'd0, '0, 1'b1, 5'h08, 32'h0000_1000, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      rd(5'd14); rd(5'd12); rd(5'd13);
      // R7 R8: boot vector and address fault
      wr(5'd12, 32'h0040_0000);
      step(1'b0, 5'd8, '0, 1'b1, 5'h04, 32'hDEAD_0000, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      rd(5'd8);
      step(1'b0, 5'd8, '0, 1'b1, 5'h0C, 32'h1111_0000, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      rd(5'd8); rd(5'd14);
      // R9 R10: masked interrupt only pends, enabled one is taken
      wr(5'd13, 32'h0);
      wr(5'd12, 32'h0000_0001);
      step(1'b0, 5'd13, '0, 1'b0, '0, 32'h2000, 1'b0, 1'b0, 1'b1, 1'b0, '0);
      rd(5'd13); rd(5'd14);
      wr(5'd12, 32'h0000_0401);
      step(1'b0, 5'd12, '0, 1'b0, '0, 32'h3000, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      rd(5'd12); rd(5'd13); rd(5'd14);
      // R11: return keeps the old pair, other function codes do nothing
      wr(5'd12, 32'h0000_0030);
      step(1'b0, 5'd12, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h10);
      rd(5'd12);
      step(1'b0, 5'd12, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h01);
      rd(5'd12);
      // R12: exception beats writes and interrupt; return beats Status write
      wr(5'd12, 32'h0000_0401);
      step(1'b1, 5'd12, 32'hFFFF_FFFF, 1'b1, 5'h09, 32'h4000, 1'b0, 1'b0, 1'b1, 1'b0, '0);
      rd(5'd12); rd(5'd13);
      step(1'b1, 5'd13, 32'h0000_0000, 1'b1, 5'h0A, 32'h5000, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      rd(5'd13);
      wr(5'd12, 32'h0000_0030);
      step(1'b1, 5'd12, 32'hAAAA_0000, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h10);
      rd(5'd12);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [4:0] a;
         logic [31:0] d;
         a = ($urandom % 4 == 0) ? 5'd12 + 5'($urandom % 2) : 5'($urandom % 16);
         d = $urandom;
         if (a == 5'd12 && ($urandom % 2) == 1) d[22] = 1'b0;
         step(($urandom % 3) == 0, a, d,
              ($urandom % 6) == 0, 5'($urandom), {$urandom, 2'b00} >> 2 << 2,
              1'($urandom), 1'($urandom), ($urandom % 4) == 0,
              ($urandom % 8) == 0, ($urandom % 2) ? 6'h10 : 6'($urandom));
      end
      done = 1'b1;
      finish_run();
   end
endmodule